// File: doc/BRIEF.md
# Pseudo-Static RAM Host Controller

This block connects a simple synchronous host request port to a 128K x 8 pseudo-static RAM whose address is not multiplexed. The host presents a request together with an operation (read, write or read-modify-write), a 17-bit address and a write byte. The controller accepts the request when `req_ready` is high. It runs the matching RAM cycle on the active-low chip enable, output enable, write enable and refresh strobes, drives the active-high chip select, and returns read bytes with a one-cycle `rd_valid` pulse. Every cycle count comes from a nanosecond parameter divided by the clock period and rounded up.

The controller is built around one state machine with these states: ST_POWERUP, ST_DUMMY, ST_DUMMY_PRE, ST_IDLE, ST_ACCESS, ST_RMW_WR, ST_PRECHARGE, ST_RF_PULSE and ST_RF_GAP. After reset the machine waits in ST_POWERUP for the power-up time. It then alternates between ST_DUMMY and ST_DUMMY_PRE for nine warm-up cycles and enters ST_IDLE. From ST_IDLE, a pending refresh moves it to ST_RF_PULSE, then to ST_RF_GAP, and back to ST_IDLE. Otherwise an accepted request moves it to ST_ACCESS. After ST_ACCESS, a read-modify-write goes on to ST_RMW_WR and then to ST_PRECHARGE; a read or write goes straight to ST_PRECHARGE. ST_PRECHARGE returns to ST_IDLE. A free-running interval counter raises a refresh request about every 15.6 µs. The request is served at the next idle boundary, and the host is held off while it waits.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low and no chip-enable fall occurs for the power-up wait (100 µs, 10000 cycles at 10 ns). Exactly 9 dummy cycles then follow, with chip enable low, write enable high and output enable high, before `req_ready` first rises.
- R2: A read (`req_op` = 2'b00) holds chip enable and output enable low together for 7 cycles, which is the larger of the minimum enable width and the access time. The byte on `ram_dq_in` at the end of that window is returned on `rd_data` with `rd_valid` high for exactly one cycle, 7 cycles after the cycle in which the request is accepted.
- R3: A write (`req_op` = 2'b01) holds chip enable and write enable low together for 7 cycles with output enable high. `ram_dq_oe` is high for the whole write-enable-low window. The byte is stored when write enable and chip enable rise together.
- R4: A read-modify-write (`req_op` = 2'b10) keeps chip enable low for 10 cycles. Output enable is low for the first 7 cycles; output enable is then high and write enable low, with the bus driven, for the last 3. The old byte is returned on `rd_data` and the new byte is stored.
- R5: Chip enable stays high for at least 5 cycles after a read, write or dummy cycle and at least 7 cycles after a read-modify-write before it falls again. These counts satisfy the 40 ns precharge and the 120 ns and 170 ns minimum cycle times.
- R6: While chip enable is low, `ram_addr` equals the accepted address and does not change, and `ram_sel` is high.
- R7: A refresh drives `ram_rfsh_n` low for exactly 3 cycles while chip enable is high. The fall comes at least 4 cycles after chip enable rose. Successive refresh falls are 1560 cycles apart, within the length of one host cycle, so that 512 refreshes complete within every 8 ms.
- R8: A pending refresh takes priority at the next idle boundary. `req_ready` is low while a refresh is pending or in progress, and an access that has started is never cut short.
- R9: Write enable is never low while chip enable is high, and the data bus is never driven while output enable is low.
- R10: `req_op` = 2'b11 behaves exactly as a read.
- R11: A request is taken only on a cycle with `req_valid` and `req_ready` both high, and `req_ready` is low in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_op | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to store (write, read-modify-write) |
| req_ready | output | 1 | Controller can take a request this cycle |
| rd_valid | output | 1 | One-cycle pulse with returned byte |
| rd_data | output | 8 | Returned byte |
| ram_addr | output | 17 | RAM address bus |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_sel | output | 1 | RAM chip select, active high |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_rfsh_n | output | 1 | RAM refresh strobe, active low |
| ram_dq_out | output | 8 | Data driven toward the RAM |
| ram_dq_in | input | 8 | Data returned from the RAM |
| ram_dq_oe | output | 1 | Enable for the data bus driver |

## Verification
The embedded properties watch, on every cycle, the exclusions between the strobes: write enable only inside chip enable, refresh only while chip enable is high, and no bus drive while output enable is low. They also check address hold across the chip-enable window, the ready hold-off while a refresh is pending, and the countdown and refresh-request bookkeeping. Strobe pulse widths, precharge gaps, the refresh spacing, the power-up wait with its dummy-cycle count, and correct data through every operation type are visible only to the bench. It sweeps 64 addresses through writes, reads, read-modify-writes and the alternate read encoding against a behavioural RAM model, and then leaves the bus idle to measure refresh intervals.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_DUMMY,
        ST_DUMMY_PRE,
        ST_IDLE,
        ST_ACCESS,
        ST_RMW_WR,
        ST_PRECHARGE,
        ST_RF_PULSE,
        ST_RF_GAP
    } psram_state_e;

    typedef enum logic [1:0] {
        OP_READ     = 2'b00,
        OP_WRITE    = 2'b01,
        OP_RMW      = 2'b10,
        OP_READ_ALT = 2'b11
    } psram_op_e;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
    parameter int W    = 14,
    parameter int INIT = 9999
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= W'(INIT);
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - {{(W-1){1'b0}}, 1'b1};
        end
    end

    assign done = (count == '0);

    // R5: window lengths rely on a strict one-per-cycle countdown
    p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count != '0) |=> (count == $past(count) - {{(W-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/psram_refresh_sched.sv
module psram_refresh_sched #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic grant,
    output logic pending
);

    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = enable && (cnt == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            if (enable) begin
                cnt <= tick ? '0 : cnt + {{(CW-1){1'b0}}, 1'b1};
            end
            if (tick) begin
                pending <= 1'b1;
            end else if (grant) begin
                pending <= 1'b0;
            end
        end
    end

    // R7: a served refresh request is retired
    p_grant_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !tick) |=> !pending);

    // R8: a request waits until the state machine grants it
    p_pending_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !grant) |=> pending);

endmodule

// File: rtl/psram_datapath.sv
module psram_datapath #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [1:0]    in_op,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [1:0]    op_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            op_q    <= in_op;
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= dq_in;
            end
        end
    end

    // R2: returned data is a single-cycle pulse
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int AW           = 17,
    parameter int DW           = 8,
    parameter int CLK_NS       = 10,
    parameter int T_CYCLE_NS   = 120,
    parameter int T_RMW_NS     = 170,
    parameter int T_CE_MIN_NS  = 70,
    parameter int T_ACCESS_NS  = 70,
    parameter int T_PRECH_NS   = 40,
    parameter int T_WE_MIN_NS  = 25,
    parameter int T_DSETUP_NS  = 25,
    parameter int T_CE2RF_NS   = 40,
    parameter int T_RF_LOW_NS  = 30,
    parameter int T_RF_HIGH_NS = 30,
    parameter int T_RF_CYC_NS  = 120,
    parameter int REFRESH_NS   = 15600,
    parameter int POWERUP_NS   = 100000,
    parameter int DUMMY_CYCLES = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] ram_addr,
    output logic          ram_ce_n,
    output logic          ram_sel,
    output logic          ram_oe_n,
    output logic          ram_we_n,
    output logic          ram_rfsh_n,
    output logic [DW-1:0] ram_dq_out,
    input  logic [DW-1:0] ram_dq_in,
    output logic          ram_dq_oe
);

    localparam int CE_CYC    = imax(ns_to_cyc(T_CE_MIN_NS, CLK_NS), ns_to_cyc(T_ACCESS_NS, CLK_NS));
    localparam int WE_CYC    = imax(ns_to_cyc(T_WE_MIN_NS, CLK_NS), ns_to_cyc(T_DSETUP_NS, CLK_NS));
    localparam int GAP_MIN   = imax(ns_to_cyc(T_PRECH_NS, CLK_NS), ns_to_cyc(T_CE2RF_NS, CLK_NS));
    localparam int PRE_CYC   = imax(GAP_MIN, ns_to_cyc(T_CYCLE_NS, CLK_NS) - CE_CYC);
    localparam int PRE_RMW   = imax(GAP_MIN, ns_to_cyc(T_RMW_NS, CLK_NS) - CE_CYC - WE_CYC);
    localparam int RF_LOW    = ns_to_cyc(T_RF_LOW_NS, CLK_NS);
    localparam int RF_GAP    = imax(ns_to_cyc(T_RF_HIGH_NS, CLK_NS), ns_to_cyc(T_RF_CYC_NS, CLK_NS) - RF_LOW);
    localparam int REF_CYC   = REFRESH_NS / CLK_NS;
    localparam int PWR_CYC   = ns_to_cyc(POWERUP_NS, CLK_NS);
    localparam int TMAX      = imax(imax(PWR_CYC, CE_CYC), imax(imax(PRE_CYC, PRE_RMW), RF_GAP));
    localparam int TW        = $clog2(TMAX + 1);
    localparam int DCW       = $clog2(DUMMY_CYCLES + 1);

    psram_state_e state_q, state_d;

    logic          t_load, t_done;
    logic [TW-1:0] t_val;
    logic          grant, accept, capture, dmy_dec, init_done;
    logic          ref_pending;
    logic [DCW-1:0] dmy_left;
    logic [1:0]    op_q;
    logic [DW-1:0] wdata_q;

    psram_timer #(.W(TW), .INIT(PWR_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    psram_refresh_sched #(.PERIOD(REF_CYC)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (init_done),
        .grant   (grant),
        .pending (ref_pending)
    );

    psram_datapath #(.AW(AW), .DW(DW)) u_datapath (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .in_op    (req_op),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .capture  (capture),
        .dq_in    (ram_dq_in),
        .op_q     (op_q),
        .addr_q   (ram_addr),
        .wdata_q  (wdata_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // state register and warm-up counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_POWERUP;
            dmy_left <= DCW'(DUMMY_CYCLES);
        end else begin
            state_q <= state_d;
            if (dmy_dec) begin
                dmy_left <= dmy_left - {{(DCW-1){1'b0}}, 1'b1};
            end
        end
    end

    // next state, timer loads and handshakes
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        grant   = 1'b0;
        accept  = 1'b0;
        capture = 1'b0;
        dmy_dec = 1'b0;
        unique case (state_q)
            ST_POWERUP: begin
                if (t_done) begin
                    state_d = ST_DUMMY;
                    t_load  = 1'b1;
                    t_val   = TW'(CE_CYC - 1);
                end
            end
            ST_DUMMY: begin
                if (t_done) begin
                    state_d = ST_DUMMY_PRE;
                    t_load  = 1'b1;
                    t_val   = TW'(PRE_CYC - 1);
                end
            end
            ST_DUMMY_PRE: begin
                if (t_done) begin
                    dmy_dec = 1'b1;
                    if (dmy_left == DCW'(1)) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_DUMMY;
                        t_load  = 1'b1;
                        t_val   = TW'(CE_CYC - 1);
                    end
                end
            end
            ST_IDLE: begin
                if (ref_pending) begin
                    state_d = ST_RF_PULSE;
                    grant   = 1'b1;
                    t_load  = 1'b1;
                    t_val   = TW'(RF_LOW - 1);
                end else if (req_valid) begin
                    state_d = ST_ACCESS;
                    accept  = 1'b1;
                    t_load  = 1'b1;
                    t_val   = TW'(CE_CYC - 1);
                end
            end
            ST_ACCESS: begin
                if (t_done) begin
                    t_load  = 1'b1;
                    capture = (op_q != OP_WRITE);
                    if (op_q == OP_RMW) begin
                        state_d = ST_RMW_WR;
                        t_val   = TW'(WE_CYC - 1);
                    end else begin
                        state_d = ST_PRECHARGE;
                        t_val   = TW'(PRE_CYC - 1);
                    end
                end
            end
            ST_RMW_WR: begin
                if (t_done) begin
                    state_d = ST_PRECHARGE;
                    t_load  = 1'b1;
                    t_val   = TW'(PRE_RMW - 1);
                end
            end
            ST_PRECHARGE: begin
                if (t_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RF_PULSE: begin
                if (t_done) begin
                    state_d = ST_RF_GAP;
                    t_load  = 1'b1;
                    t_val   = TW'(RF_GAP - 1);
                end
            end
            ST_RF_GAP: begin
                if (t_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_POWERUP;
            end
        endcase
    end

    // strobe decode
    always_comb begin
        ram_ce_n   = 1'b1;
        ram_sel    = 1'b0;
        ram_oe_n   = 1'b1;
        ram_we_n   = 1'b1;
        ram_rfsh_n = 1'b1;
        ram_dq_oe  = 1'b0;
        unique case (state_q)
            ST_DUMMY: begin
                ram_ce_n = 1'b0;
                ram_sel  = 1'b1;
            end
            ST_ACCESS: begin
                ram_ce_n = 1'b0;
                ram_sel  = 1'b1;
                if (op_q == OP_WRITE) begin
                    ram_we_n  = 1'b0;
                    ram_dq_oe = 1'b1;
                end else begin
                    ram_oe_n = 1'b0;
                end
            end
            ST_RMW_WR: begin
                ram_ce_n  = 1'b0;
                ram_sel   = 1'b1;
                ram_we_n  = 1'b0;
                ram_dq_oe = 1'b1;
            end
            ST_RF_PULSE: begin
                ram_rfsh_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign init_done  = (state_q != ST_POWERUP) && (state_q != ST_DUMMY) && (state_q != ST_DUMMY_PRE);
    assign req_ready  = (state_q == ST_IDLE) && !ref_pending;
    assign ram_dq_out = wdata_q;

    // R9: write strobe only inside a chip-enable window
    p_we_in_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> !ram_ce_n);

    // R9: no bus drive while the RAM may be driving
    p_bus_vs_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n);

    // R7: refresh strobe only with chip enable high
    p_rfsh_ce_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_rfsh_n |-> ram_ce_n);

    // R6: address held through the chip-enable window
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));

    // R8: host held off while a refresh waits
    p_ready_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !ref_pending);

endmodule

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CE_CYC     = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int WE_RMW     = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RMW_CE     = CE_CYC + WE_RMW;
    localparam int PRE        = 5;
    localparam int PRE_RMW    = 7;
    localparam int RF_LOW     = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RFD        = (40 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int REF        = 15600 / CLK_PERIOD;
    localparam int PWR        = 100000 / CLK_PERIOD;
    localparam int NDUMMY     = 9;
    localparam int NADDR      = 64;

    logic        clk, rst_n;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [16:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] ram_addr;
    logic        ram_ce_n, ram_sel, ram_oe_n, ram_we_n, ram_rfsh_n, ram_dq_oe;
    logic [7:0]  ram_dq_out, ram_dq_in;

    psram_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .ram_addr   (ram_addr),
        .ram_ce_n   (ram_ce_n),
        .ram_sel    (ram_sel),
        .ram_oe_n   (ram_oe_n),
        .ram_we_n   (ram_we_n),
        .ram_rfsh_n (ram_rfsh_n),
        .ram_dq_out (ram_dq_out),
        .ram_dq_in  (ram_dq_in),
        .ram_dq_oe  (ram_dq_oe)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural RAM model and strobe monitor
    logic [7:0]  model_mem [1024];
    logic [16:0] lat_addr = '0;
    logic [16:0] exp_addr = '0;
    int  cyc = 0;
    int  ce_low_cnt = 0, ce_high_cnt = 1000, we_low_cnt = 0, rf_low_cnt = 0;
    bit  ce_prev = 1, we_prev = 1, rf_prev = 1;
    bit  run_oe = 0, run_we = 0, last_rmw = 0;
    bit  addr_bad = 0, sel_bad = 0, dq_bad = 0, rf_ready_bad = 0, r9_bad = 0, dummy_we = 0;
    bit  ready_seen = 0;
    int  first_ce_cyc = -1, rf_last_cyc = -1, rf_count = 0, ce_falls_pre_ready = 0;

    assign ram_dq_in = (!ram_ce_n && !ram_oe_n && ce_low_cnt >= CE_CYC)
                       ? model_mem[lat_addr[9:0]] : 8'h00;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ram_ce_n && ce_prev) begin
                chk(ce_high_cnt >= (last_rmw ? PRE_RMW : PRE), "R5 precharge before chip enable",
                    ce_high_cnt, last_rmw ? PRE_RMW : PRE);
                if (first_ce_cyc < 0) first_ce_cyc = cyc;
                if (!ready_seen) ce_falls_pre_ready++;
                else chk(ram_addr == exp_addr, "R6 address at chip-enable fall", ram_addr, exp_addr);
                lat_addr = ram_addr;
                ce_low_cnt = 0; run_oe = 0; run_we = 0; addr_bad = 0; sel_bad = 0;
            end
            if (!ram_ce_n) begin
                ce_low_cnt++;
                if (!ram_oe_n) run_oe = 1;
                if (!ram_we_n) run_we = 1;
                if (ram_addr != lat_addr) addr_bad = 1;
                if (!ram_sel) sel_bad = 1;
                if (!ram_we_n && ram_dq_oe) model_mem[lat_addr[9:0]] = ram_dq_out;
                if (!ready_seen && (!ram_we_n || !ram_oe_n)) dummy_we = 1;
            end
            if (ram_we_n && !we_prev) begin
                chk(we_low_cnt == (run_oe ? WE_RMW : CE_CYC), "R3 R4 write-enable width",
                    we_low_cnt, run_oe ? WE_RMW : CE_CYC);
                chk(!dq_bad, "R3 bus driven while write enable low", dq_bad, 0);
            end
            if (!ram_we_n) begin
                if (we_prev) begin we_low_cnt = 0; dq_bad = 0; end
                we_low_cnt++;
                if (!ram_dq_oe) dq_bad = 1;
            end
            if ((!ram_we_n && ram_ce_n) || (ram_dq_oe && !ram_oe_n)) r9_bad = 1;
            if (ram_ce_n && !ce_prev) begin
                chk(ce_low_cnt == ((run_oe && run_we) ? RMW_CE : CE_CYC), "R2 R3 R4 chip-enable width",
                    ce_low_cnt, (run_oe && run_we) ? RMW_CE : CE_CYC);
                chk(!addr_bad, "R6 address stable", addr_bad, 0);
                chk(!sel_bad, "R6 select high", sel_bad, 0);
                last_rmw = run_oe && run_we;
                ce_high_cnt = 0;
            end
            if (ram_ce_n) ce_high_cnt++;
            if (!ram_rfsh_n && rf_prev) begin
                chk(ram_ce_n && ce_high_cnt >= RFD, "R7 chip enable to refresh spacing", ce_high_cnt, RFD);
                if (rf_last_cyc >= 0)
                    chk((cyc - rf_last_cyc) >= REF - 24 && (cyc - rf_last_cyc) <= REF + 24,
                        "R7 refresh interval", cyc - rf_last_cyc, REF);
                rf_last_cyc = cyc;
                rf_count++;
                rf_low_cnt = 0;
                rf_ready_bad = 0;
            end
            if (!ram_rfsh_n) begin
                rf_low_cnt++;
                if (req_ready || !ram_ce_n) rf_ready_bad = 1;
            end
            if (ram_rfsh_n && !rf_prev) begin
                chk(rf_low_cnt == RF_LOW, "R7 refresh width", rf_low_cnt, RF_LOW);
                chk(!rf_ready_bad, "R8 ready low during refresh", rf_ready_bad, 0);
            end
            ce_prev = ram_ce_n; we_prev = ram_we_n; rf_prev = ram_rfsh_n;
            if (req_ready) ready_seen = 1;
        end
    end

    task automatic host_op(input logic [1:0] op, input logic [16:0] a, input logic [7:0] d,
                           output logic [7:0] rd, output int lat);
        int wd;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        exp_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11 ready drops after acceptance", req_ready, 0);
        rd = '0;
        lat = 0;
        if (op != 2'b01) begin
            wd = 0;
            while (!rd_valid && wd < 200) begin
                @(negedge clk);
                wd++;
            end
            rd = rd_data;
            lat = wd;
        end
    endtask

    function automatic logic [16:0] addr_of(input int i);
        return 17'((i * 1031 + 5) % 131072);
    endfunction

    function automatic logic [7:0] data_of(input int i);
        return 8'((i * 37 + 11) % 256);
    endfunction

    initial begin
        logic [7:0] rd;
        int lat, rc0, rc1;
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
        repeat (5) @(negedge clk);
        chk(!req_ready && ram_ce_n && ram_we_n && ram_rfsh_n && !ram_dq_oe && !rd_valid,
            "R1 reset state", req_ready, 0);
        rst_n = 1'b1;
        while (!req_ready && cyc < PWR + 3000) @(negedge clk);
        chk(req_ready, "R1 ready after initialisation", req_ready, 1);
        chk(first_ce_cyc >= PWR, "R1 power-up wait", first_ce_cyc, PWR);
        chk(ce_falls_pre_ready == NDUMMY, "R1 dummy cycle count", ce_falls_pre_ready, NDUMMY);
        chk(!dummy_we, "R1 dummy cycles inert", dummy_we, 0);

        rc0 = rf_count;
        for (int i = 0; i < NADDR; i++) host_op(2'b01, addr_of(i), data_of(i), rd, lat);
        for (int i = 0; i < NADDR; i++) begin
            host_op(2'b00, addr_of(i), 8'h00, rd, lat);
            chk(rd == data_of(i), "R2 R3 read returns written byte", rd, data_of(i));
            chk(lat == CE_CYC, "R2 read latency", lat, CE_CYC);
        end
        for (int i = 0; i < NADDR; i++) begin
            host_op(2'b10, addr_of(i), ~data_of(i), rd, lat);
            chk(rd == data_of(i), "R4 modify returns old byte", rd, data_of(i));
            chk(lat == CE_CYC, "R4 modify read latency", lat, CE_CYC);
        end
        for (int i = 0; i < NADDR; i++) begin
            host_op(2'b11, addr_of(i), 8'h00, rd, lat);
            chk(rd == ~data_of(i), "R10 R4 alternate read sees new byte", rd, ~data_of(i));
        end
        rc1 = rf_count;
        chk(rc1 - rc0 >= 2, "R8 refreshes interleaved with traffic", rc1 - rc0, 2);

        repeat (3200) @(negedge clk);
        chk(rf_count - rc1 >= 2 && rf_count - rc1 <= 3, "R7 refresh count while idle", rf_count - rc1, 2);
        host_op(2'b00, addr_of(3), 8'h00, rd, lat);
        chk(rd == ~data_of(3), "R8 data intact after refreshes", rd, ~data_of(3));
        chk(!r9_bad, "R9 strobe exclusions", r9_bad, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule